// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative address translation cache. Each slot holds a virtual page number, an address-space tag, a global flag, a page-size code, a physical frame number and two permission bits (user-accessible, writable). A lookup presents a virtual page number, the current address-space tag and the access kind (user or supervisor, read or write). In the same cycle, without a register on the path, the block answers with a hit flag, the translated frame and a fault code.

Software fills the buffer through an install port. Software supplies the page data and the hardware picks the slot. An install first removes every valid slot whose mapping overlaps the new one, so a later lookup can never match two slots. Three flush commands remove entries: everything, every non-global entry of one address space, or every entry that covers one virtual page. Slot choice takes the lowest empty slot. When the buffer is full, a round-robin pointer chooses, and it steps past the most recently used slot.

Top module: `tlb_asn`

## Requirements
- R1: After reset no slot is valid, and every lookup reports lk_hit=0 with fault code 1 (miss).
- R2: A lookup that matches a valid slot reports lk_hit=1 and the slot's frame in the same cycle. A 4 KB page (size code 0) matches only its exact page number.
- R3: A non-global slot matches only when its address-space tag equals lk_asn.
- R4: A global slot matches under any lk_asn, and an address-space flush leaves it in place.
- R5: Size code 1, 2 or 3 makes a slot cover 8, 64 or 512 pages. The low 3, 6 or 9 page-number bits are ignored in the compare, and the frame's same low bits come from the looked-up page number.
- R6: lk_fault encodes 0 ok, 1 miss, 2 privilege (user access to a supervisor-only slot) and 3 write to a read-only slot, in the priority miss, privilege, read-only.
- R7: fl_cmd=1 (flush all) invalidates every slot, global ones included.
- R8: fl_cmd=2 invalidates every non-global slot whose tag equals fl_asn and nothing else.
- R9: fl_cmd=3 invalidates every slot covering fl_vpn, under any tag, global ones included.
- R10: An install first removes each valid slot whose page range overlaps the new one and that shares its tag or where either side is global. The first such slot receives the new entry, so at most one slot ever matches a lookup.
- R11: With no overlap, an install goes to the lowest invalid slot and evicts no valid entry.
- R12: With the buffer full, the round-robin pointer picks the victim. It skips the most recently used slot, which is the last install or the last hit seen with lk_valid=1.
- R13: When an install and a flush fall in the same cycle, the flush is applied first and the installed entry survives.
- R0: fl_cmd=0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup is a real access (updates recency) |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space tag |
| lk_user | input | 1 | Access made in user mode |
| lk_write | input | 1 | Access is a data write |
| lk_hit | output | 1 | A slot matched |
| lk_pfn | output | PFN_W | Translated frame (0 on miss) |
| lk_fault | output | 2 | Fault code (R6) |
| in_en | input | 1 | Install strobe |
| in_vpn | input | VPN_W | Install page number |
| in_asn | input | ASN_W | Install address-space tag |
| in_glob | input | 1 | Install as global |
| in_size | input | 2 | Install size code (R5) |
| in_pfn | input | PFN_W | Install frame |
| in_user | input | 1 | Install: user may access |
| in_write | input | 1 | Install: writes allowed |
| fl_cmd | input | 2 | Flush command: 0 none, 1 all, 2 tag, 3 page |
| fl_asn | input | ASN_W | Tag for flush command 2 |
| fl_vpn | input | VPN_W | Page for flush command 3 |

## Verification
An install and a flush can land on the same clock edge. Both change the valid vector, so their order decides whether the fresh entry lives. The bench raises in_en together with a flush-all, and again together with a tag flush naming the installed tag. It then looks the new page up (it must hit) and looks up an old page (it must miss). A second overlap occurs between a lookup hit and the victim choice. The bench makes one slot most recently used with a hit just before an install into a full buffer, and checks at the lookup port which page was evicted.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PRIV = 2'd2,
    FLT_RO   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    FL_NOP = 2'd0,
    FL_ALL = 2'd1,
    FL_ASN = 2'd2,
    FL_VA  = 2'd3
  } flush_e;

  // page-number bits that a size code makes "don't care"
  localparam int SP_BITS = 9;

  function automatic logic [SP_BITS-1:0] sp_low_mask(input logic [1:0] sz);
    case (sz)
      2'd1:    sp_low_mask = 9'h007;
      2'd2:    sp_low_mask = 9'h03F;
      2'd3:    sp_low_mask = 9'h1FF;
      default: sp_low_mask = 9'h000;
    endcase
  endfunction

endpackage

// File: rtl/tlb_asn_cam.sv
module tlb_asn_cam
  import tlb_asn_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]     e_valid,
  input  logic [N-1:0]     e_glob,
  input  logic [ASN_W-1:0] e_asn  [N],
  input  logic [VPN_W-1:0] e_vpn  [N],
  input  logic [1:0]       e_size [N],
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [1:0]       q_size,
  input  logic [ASN_W-1:0] q_asn,
  input  logic             q_glob,
  input  logic             q_any_asn,
  output logic [N-1:0]     match
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [SP_BITS-1:0] lm;
    logic               hi_eq, lo_eq, tag_ok;
    always_comb begin
      lm     = sp_low_mask(e_size[i]) | sp_low_mask(q_size);
      hi_eq  = (e_vpn[i][VPN_W-1:SP_BITS] == q_vpn[VPN_W-1:SP_BITS]);
      lo_eq  = (((e_vpn[i][SP_BITS-1:0] ^ q_vpn[SP_BITS-1:0]) & ~lm) == '0);
      tag_ok = q_any_asn | q_glob | e_glob[i] | (e_asn[i] == q_asn);
      match[i] = e_valid[i] & hi_eq & lo_eq & tag_ok;
    end
  end

endmodule

// File: rtl/tlb_asn_victim.sv
module tlb_asn_victim #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] mru,
  input  logic          adv,
  output logic [IW-1:0] slot
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  function automatic logic [IW-1:0] step(input logic [IW-1:0] x);
    step = (x == LAST) ? '0 : x + 1'b1;
  endfunction

  logic [IW-1:0] rr, rr_pick, free_idx;
  logic          free_any;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !free_any) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
    rr_pick = (rr == mru) ? step(rr) : rr;
    slot    = free_any ? free_idx : rr_pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rr <= '0;
    else if (adv && !free_any) rr <= step(rr_pick);
  end

  // R12
  victim_not_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid) |-> (slot != mru));

  // R11
  free_slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~&valid) |-> !valid[slot]);

endmodule

// File: rtl/tlb_asn.sv
module tlb_asn
  import tlb_asn_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [1:0]       lk_fault,
  input  logic             in_en,
  input  logic [VPN_W-1:0] in_vpn,
  input  logic [ASN_W-1:0] in_asn,
  input  logic             in_glob,
  input  logic [1:0]       in_size,
  input  logic [PFN_W-1:0] in_pfn,
  input  logic             in_user,
  input  logic             in_write,
  input  logic [1:0]       fl_cmd,
  input  logic [ASN_W-1:0] fl_asn,
  input  logic [VPN_W-1:0] fl_vpn
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // slot storage
  logic [N-1:0]     ent_valid, ent_glob, ent_usr, ent_wr;
  logic [ASN_W-1:0] ent_asn  [N];
  logic [VPN_W-1:0] ent_vpn  [N];
  logic [PFN_W-1:0] ent_pfn  [N];
  logic [1:0]       ent_size [N];

  // named internal events
  logic [N-1:0]  lk_match, dup_match, va_match, kill, nxt_valid;
  logic [IW-1:0] lk_idx, dup_idx, vic_slot, ins_slot, mru;
  logic          lk_any, dup_any;
  flush_e        fl;

  assign fl = flush_e'(fl_cmd);

  tlb_asn_cam #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam_lk (
    .e_valid(ent_valid), .e_glob(ent_glob), .e_asn(ent_asn), .e_vpn(ent_vpn),
    .e_size(ent_size), .q_vpn(lk_vpn), .q_size(2'd0), .q_asn(lk_asn),
    .q_glob(1'b0), .q_any_asn(1'b0), .match(lk_match));

  tlb_asn_cam #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam_dup (
    .e_valid(ent_valid), .e_glob(ent_glob), .e_asn(ent_asn), .e_vpn(ent_vpn),
    .e_size(ent_size), .q_vpn(in_vpn), .q_size(in_size), .q_asn(in_asn),
    .q_glob(in_glob), .q_any_asn(1'b0), .match(dup_match));

  tlb_asn_cam #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam_va (
    .e_valid(ent_valid), .e_glob(ent_glob), .e_asn(ent_asn), .e_vpn(ent_vpn),
    .e_size(ent_size), .q_vpn(fl_vpn), .q_size(2'd0), .q_asn(fl_asn),
    .q_glob(1'b0), .q_any_asn(1'b1), .match(va_match));

  tlb_asn_victim #(.N(N), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(ent_valid), .mru(mru),
    .adv(in_en & ~dup_any), .slot(vic_slot));

  // first-set encoders
  always_comb begin
    lk_idx  = '0; lk_any  = 1'b0;
    dup_idx = '0; dup_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i] && !lk_any) begin
        lk_idx = IW'(i);
        lk_any = 1'b1;
      end
      if (dup_match[i] && !dup_any) begin
        dup_idx = IW'(i);
        dup_any = 1'b1;
      end
    end
  end

  assign ins_slot = dup_any ? dup_idx : vic_slot;

  // lookup result: frame splice and fault priority
  logic [SP_BITS-1:0] lk_lm;
  fault_e             flt;
  always_comb begin
    lk_lm  = sp_low_mask(ent_size[lk_idx]);
    lk_hit = lk_any;
    lk_pfn = '0;
    if (lk_any)
      lk_pfn = {ent_pfn[lk_idx][PFN_W-1:SP_BITS],
                (ent_pfn[lk_idx][SP_BITS-1:0] & ~lk_lm) | (lk_vpn[SP_BITS-1:0] & lk_lm)};
    if (!lk_any)                        flt = FLT_MISS;
    else if (lk_user && !ent_usr[lk_idx])  flt = FLT_PRIV;
    else if (lk_write && !ent_wr[lk_idx])  flt = FLT_RO;
    else                                flt = FLT_NONE;
    lk_fault = flt;
  end

  // flush then install
  always_comb begin
    for (int i = 0; i < N; i++) begin
      kill[i] = (fl == FL_ALL)
              | ((fl == FL_ASN) && !ent_glob[i] && (ent_asn[i] == fl_asn))
              | ((fl == FL_VA) && va_match[i]);
    end
    nxt_valid = ent_valid & ~kill;
    if (in_en) begin
      nxt_valid = nxt_valid & ~dup_match;
      nxt_valid[ins_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      mru       <= '0;
    end else begin
      ent_valid <= nxt_valid;
      if (in_en)                  mru <= ins_slot;
      else if (lk_valid && lk_any) mru <= lk_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (in_en) begin
      ent_vpn[ins_slot]  <= in_vpn;
      ent_asn[ins_slot]  <= in_asn;
      ent_pfn[ins_slot]  <= in_pfn;
      ent_size[ins_slot] <= in_size;
      ent_glob[ins_slot] <= in_glob;
      ent_usr[ins_slot]  <= in_user;
      ent_wr[ins_slot]   <= in_write;
    end
  end

  // R10
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1);

  // R7
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl == FL_ALL && !in_en) |=> (ent_valid == '0));

  // R4
  asn_flush_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl == FL_ASN && !in_en) |=> ((ent_valid & ent_glob) == $past(ent_valid & ent_glob)));

  // R13
  install_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_en |=> ent_valid[$past(ins_slot)]);

endmodule

// File: tb/tlb_asn_test.sv
module tlb_asn_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_user, lk_write, lk_hit;
  logic [19:0] lk_vpn, lk_pfn;
  logic [7:0]  lk_asn;
  logic [1:0]  lk_fault;
  logic        in_en, in_glob, in_user, in_write;
  logic [19:0] in_vpn, in_pfn, fl_vpn;
  logic [7:0]  in_asn, fl_asn;
  logic [1:0]  in_size, fl_cmd;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_asn uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_user(lk_user),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
    .in_en(in_en), .in_vpn(in_vpn), .in_asn(in_asn), .in_glob(in_glob),
    .in_size(in_size), .in_pfn(in_pfn), .in_user(in_user), .in_write(in_write),
    .fl_cmd(fl_cmd), .fl_asn(fl_asn), .fl_vpn(fl_vpn));

  // lookup: drive at negedge, sample 1 ns later, let the hit register recency
  task automatic look(input logic [19:0] vpn, input logic [7:0] asn,
                      input logic usr, input logic wr,
                      input logic e_hit, input logic [19:0] e_pfn,
                      input logic [1:0] e_flt, input string tag);
    @(negedge clk);
    lk_vpn = vpn; lk_asn = asn; lk_user = usr; lk_write = wr; lk_valid = 1'b1;
    #1;
    checks++;
    if (lk_hit !== e_hit || lk_pfn !== e_pfn || lk_fault !== e_flt) begin
      fails++;
      $display("FAIL %s: hit=%0b pfn=%h fault=%0d expected hit=%0b pfn=%h fault=%0d",
               tag, lk_hit, lk_pfn, lk_fault, e_hit, e_pfn, e_flt);
    end
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic hit(input logic [19:0] vpn, input logic [7:0] asn,
                     input logic [19:0] pfn, input string tag);
    look(vpn, asn, 1'b0, 1'b0, 1'b1, pfn, 2'd0, tag);
  endtask

  task automatic miss(input logic [19:0] vpn, input logic [7:0] asn, input string tag);
    look(vpn, asn, 1'b0, 1'b0, 1'b0, 20'h0, 2'd1, tag);
  endtask

  task automatic install_fl(input logic [19:0] vpn, input logic [7:0] asn, input logic g,
                            input logic [1:0] sz, input logic [19:0] pfn,
                            input logic u, input logic w,
                            input logic [1:0] fc, input logic [7:0] fa);
    @(negedge clk);
    in_vpn = vpn; in_asn = asn; in_glob = g; in_size = sz; in_pfn = pfn;
    in_user = u; in_write = w; in_en = 1'b1;
    fl_cmd = fc; fl_asn = fa;
    @(posedge clk);
    #1 in_en = 1'b0; fl_cmd = 2'd0;
  endtask

  task automatic install(input logic [19:0] vpn, input logic [7:0] asn, input logic g,
                         input logic [1:0] sz, input logic [19:0] pfn);
    install_fl(vpn, asn, g, sz, pfn, 1'b1, 1'b1, 2'd0, 8'h0);
  endtask

  task automatic flush(input logic [1:0] fc, input logic [7:0] fa, input logic [19:0] fv);
    @(negedge clk);
    fl_cmd = fc; fl_asn = fa; fl_vpn = fv;
    @(posedge clk);
    #1 fl_cmd = 2'd0;
  endtask

  task automatic t_reset();
    miss(20'h12345, 8'd3, "R1 empty after reset");
  endtask

  task automatic t_basic();
    install(20'h12345, 8'd3, 1'b0, 2'd0, 20'hABCDE);
    hit(20'h12345, 8'd3, 20'hABCDE, "R2 exact hit");
    miss(20'h12344, 8'd3, "R2 neighbour page");
    miss(20'h12345, 8'd4, "R3 other tag");
    flush(2'd0, 8'd3, 20'h12345);
    hit(20'h12345, 8'd3, 20'hABCDE, "R0 no-op flush");
  endtask

  task automatic t_global();
    install(20'h00100, 8'd9, 1'b1, 2'd0, 20'h00777);
    install(20'h00200, 8'd9, 1'b0, 2'd0, 20'h00888);
    hit(20'h00100, 8'h55, 20'h00777, "R4 global any tag");
    flush(2'd2, 8'd3, 20'h0);
    miss(20'h12345, 8'd3, "R8 tag flush removes");
    hit(20'h00200, 8'd9, 20'h00888, "R8 other tag kept");
    flush(2'd2, 8'd9, 20'h0);
    miss(20'h00200, 8'd9, "R8 tag flush");
    hit(20'h00100, 8'd9, 20'h00777, "R4 global survives tag flush");
    flush(2'd1, 8'd0, 20'h0);
    miss(20'h00100, 8'd9, "R7 flush all");
  endtask

  task automatic t_super();
    install(20'h40040, 8'd1, 1'b0, 2'd2, 20'h80000);
    hit(20'h4007F, 8'd1, 20'h8003F, "R5 64-page");
    miss(20'h40080, 8'd1, "R5 64-page edge");
    install(20'h60000, 8'd1, 1'b0, 2'd3, 20'h12200);
    hit(20'h601FF, 8'd1, 20'h123FF, "R5 512-page");
    install(20'h00018, 8'd1, 1'b0, 2'd1, 20'h00050);
    hit(20'h0001D, 8'd1, 20'h00055, "R5 8-page");
    miss(20'h00020, 8'd1, "R5 8-page edge");
  endtask

  task automatic t_va();
    flush(2'd3, 8'd0, 20'h4005A);
    miss(20'h40040, 8'd1, "R9 page flush in superpage");
    hit(20'h601FF, 8'd1, 20'h123FF, "R9 unrelated kept");
    install(20'h00300, 8'd2, 1'b1, 2'd0, 20'h00333);
    flush(2'd3, 8'd7, 20'h00300);
    miss(20'h00300, 8'd2, "R9 global page flushed");
  endtask

  task automatic t_perm();
    flush(2'd1, 8'd0, 20'h0);
    install_fl(20'h00A00, 8'd1, 1'b0, 2'd0, 20'h00B00, 1'b0, 1'b0, 2'd0, 8'd0);
    look(20'h00A00, 8'd1, 1'b1, 1'b0, 1'b1, 20'h00B00, 2'd2, "R6 user on supervisor");
    look(20'h00A00, 8'd1, 1'b1, 1'b1, 1'b1, 20'h00B00, 2'd2, "R6 priv over ro");
    look(20'h00A00, 8'd1, 1'b0, 1'b1, 1'b1, 20'h00B00, 2'd3, "R6 write read-only");
    look(20'h00A00, 8'd1, 1'b0, 1'b0, 1'b1, 20'h00B00, 2'd0, "R6 ok");
    install_fl(20'h00A01, 8'd1, 1'b0, 2'd0, 20'h00B01, 1'b1, 1'b0, 2'd0, 8'd0);
    look(20'h00A01, 8'd1, 1'b1, 1'b1, 1'b1, 20'h00B01, 2'd3, "R6 user write ro");
  endtask

  task automatic t_dup();
    flush(2'd1, 8'd0, 20'h0);
    install(20'h05000, 8'd1, 1'b0, 2'd0, 20'h11111);
    install(20'h05000, 8'd1, 1'b0, 2'd0, 20'h22222);
    hit(20'h05000, 8'd1, 20'h22222, "R10 overwrite same page");
    install(20'h05001, 8'd1, 1'b0, 2'd0, 20'h33333);
    install(20'h05000, 8'd1, 1'b0, 2'd1, 20'h44440);
    hit(20'h05001, 8'd1, 20'h44441, "R10 superpage replaces small");
    install(20'h06000, 8'd1, 1'b0, 2'd0, 20'h00001);
    install(20'h06000, 8'd2, 1'b1, 2'd0, 20'h00002);
    hit(20'h06000, 8'd1, 20'h00002, "R10 global replaces tagged");
  endtask

  task automatic t_repl();
    flush(2'd1, 8'd0, 20'h0);
    for (int i = 0; i < 8; i++)
      install(20'h00100 + 20'(i), 8'd1, 1'b0, 2'd0, 20'h00200 + 20'(i));
    flush(2'd3, 8'd0, 20'h00103);
    install(20'h00110, 8'd1, 1'b0, 2'd0, 20'h00210);
    hit(20'h00110, 8'd1, 20'h00210, "R11 free slot used");
    hit(20'h00101, 8'd1, 20'h00201, "R11 no eviction");
    hit(20'h00107, 8'd1, 20'h00207, "R11 no eviction");
    hit(20'h00100, 8'd1, 20'h00200, "R11 no eviction");
    install(20'h00120, 8'd1, 1'b0, 2'd0, 20'h00220);
    miss(20'h00101, 8'd1, "R12 pointer skipped recent slot");
    hit(20'h00100, 8'd1, 20'h00200, "R12 recent slot kept");
    hit(20'h00120, 8'd1, 20'h00220, "R12 new entry");
    install(20'h00121, 8'd1, 1'b0, 2'd0, 20'h00221);
    miss(20'h00102, 8'd1, "R12 pointer advanced");
    hit(20'h00104, 8'd1, 20'h00204, "R12 others kept");
  endtask

  task automatic t_same_cycle();
    install_fl(20'h07777, 8'd5, 1'b0, 2'd0, 20'h0F0F0, 1'b1, 1'b1, 2'd1, 8'd0);
    hit(20'h07777, 8'd5, 20'h0F0F0, "R13 install beats flush all");
    miss(20'h00100, 8'd1, "R13 flush all applied");
    install_fl(20'h08888, 8'd6, 1'b0, 2'd0, 20'h0E0E0, 1'b1, 1'b1, 2'd2, 8'd6);
    hit(20'h08888, 8'd6, 20'h0E0E0, "R13 install beats tag flush");
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 0; lk_user = 0; lk_write = 0; lk_vpn = 0; lk_asn = 0;
    in_en = 0; in_glob = 0; in_user = 0; in_write = 0; in_vpn = 0; in_pfn = 0;
    in_asn = 0; in_size = 0; fl_cmd = 0; fl_asn = 0; fl_vpn = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_global();
    t_super();
    t_va();
    t_perm();
    t_dup();
    t_repl();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule